// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a progressive video output: a horizontal sync, a vertical sync, a data-enable window, and the current pixel and line position. The caller selects the format with a video identification code, and three formats are built in: 640x480, 1280x720 and 1920x1080. Each built-in format gives, for each axis, an active size, a front porch, a sync width, a back porch and a sync polarity. From these the block derives the last count of each axis and the first and past-the-end counts of the active window. It checks every derived value against a configurable count range and only then runs the pixel and line counters.

A new code takes effect only at a frame boundary, so a change in the middle of a frame never tears the current frame. An unknown code or a derived value outside the range raises an error flag and holds every output low. While the block is in that error state it samples the code on every cycle, and a valid code starts a clean frame at once. A 32-bit frame-control word reports the polarity flags at fixed bit positions for a downstream encoder. For short simulation rasters the `ACT_SHIFT` parameter shrinks the active sizes and leaves the porches as they are.

Top module: `vtg_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hsync_o, vsync_o, de_o, err_o, pix_x_o, line_y_o and frame_ctl_o are all 0.
- R2: Code 1 selects a horizontal axis of active 640, front porch 16, sync 96, back porch 48, and a vertical axis of active 480, front porch 10, sync 2, back porch 33, with both syncs active low.
- R3: pix_x_o counts 0 to HT and wraps to 0, with HT = active + front porch + back porch + sync - 1. line_y_o steps by one at each wrap and runs 0 to VT (same formula on the vertical axis). After the last pixel of line VT, the next position is (0,0).
- R4: de_o is 1 exactly when HS <= pix_x_o < HE and VS <= line_y_o < VE. Here HS = back porch + sync, HE = HT + 1 - front porch, VS = back porch + sync - 1 and VE = VT - front porch.
- R5: The sync of an axis is asserted while its counter is below that axis's sync width. Asserted means 1 for an active-high axis and 0 for an active-low axis.
- R6: frame_ctl_o has bit 31 (interlace) always 0, bit 29 set when horizontal sync is active low, bit 28 set when vertical sync is active low, and every other bit 0.
- R7: vic_i is sampled only on the last pixel of the last line of a frame, or on any cycle while the block is idle. A change in the middle of a frame does not alter timing or frame_ctl_o until the next frame starts.
- R8: A code other than 1, 4 or 16, once sampled, sets err_o to 1 and holds de_o, hsync_o, vsync_o, pix_x_o, line_y_o and frame_ctl_o at 0. When a valid code is present while in that state, err_o clears on the next cycle and counting starts from (0,0).
- R9: If any derived total, start or end value is 2**RANGE_BITS or more, the format is rejected in the same way as R8.
- R10: Code 4 selects horizontal 1280/110/40/220 and vertical 720/5/5/20, given as active, front porch, sync and back porch. Code 16 selects horizontal 1920/88/44/148 and vertical 1080/4/5/36 in the same order. Both codes use active-high syncs.
- R11: The active size of each axis is the nominal value shifted right by ACT_SHIFT bits. The porches and sync widths are not scaled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vic_i | input | CODE_W | Video identification code selecting the format |
| hsync_o | output | 1 | Horizontal sync at the format's polarity |
| vsync_o | output | 1 | Vertical sync at the format's polarity |
| de_o | output | 1 | Data enable, high inside the active window |
| pix_x_o | output | RANGE_BITS | Current pixel count within the line |
| line_y_o | output | RANGE_BITS | Current line count within the frame |
| frame_ctl_o | output | 32 | Frame control flags (bits 31, 29, 28) |
| err_o | output | 1 | Unknown code or out-of-range timing |

## Verification
Each of the three codes is run for one whole frame. The measured line length, frame height, data-enable count, first and last active positions and sync widths separate the three formats from one another. They also expose the differing start conventions of the horizontal and vertical axes and any polarity mix-up. A second instance with a narrow count range receives the same codes, so the range check accepts the small format and rejects the two larger ones. Directed steps check that a code change in the middle of a frame waits for the boundary, that an unknown code idles the outputs, and that a valid code restarts the raster in the very next cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CW = 16;
  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t act;
    cnt_t fp;
    cnt_t sw;
    cnt_t bp;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
    logic  h_low;
    logic  v_low;
    logic  known;
  } preset_t;

  typedef struct packed {
    cnt_t total;
    cnt_t start;
    cnt_t stop;
  } span_t;

  localparam int VIC_SD   = 1;
  localparam int VIC_HD   = 4;
  localparam int VIC_FHD  = 16;

  function automatic axis_t mk_axis(int act, int fp, int sw, int bp, int shift);
    axis_t a;
    a.act = cnt_t'(act >> shift);
    a.fp  = cnt_t'(fp);
    a.sw  = cnt_t'(sw);
    a.bp  = cnt_t'(bp);
    return a;
  endfunction
endpackage

// File: rtl/vtg_preset.sv
module vtg_preset
  import vtg_pkg::*;
#(
  parameter int CODE_W    = 7,
  parameter int ACT_SHIFT = 0
) (
  input  logic [CODE_W-1:0] code,
  output preset_t           pre
);
  always_comb begin
    pre = '0;
    case (code)
      CODE_W'(VIC_SD): begin
        pre.h     = mk_axis(640, 16, 96, 48, ACT_SHIFT);
        pre.v     = mk_axis(480, 10, 2, 33, ACT_SHIFT);
        pre.h_low = 1'b1;
        pre.v_low = 1'b1;
        pre.known = 1'b1;
      end
      CODE_W'(VIC_HD): begin
        pre.h     = mk_axis(1280, 110, 40, 220, ACT_SHIFT);
        pre.v     = mk_axis(720, 5, 5, 20, ACT_SHIFT);
        pre.known = 1'b1;
      end
      CODE_W'(VIC_FHD): begin
        pre.h     = mk_axis(1920, 88, 44, 148, ACT_SHIFT);
        pre.v     = mk_axis(1080, 4, 5, 36, ACT_SHIFT);
        pre.known = 1'b1;
      end
      default: pre = '0;
    endcase
  end
endmodule

// File: rtl/vtg_axis_calc.sv
module vtg_axis_calc
  import vtg_pkg::*;
#(
  parameter bit IS_VERT = 1'b0,
  parameter int RB      = 13
) (
  input  axis_t ax,
  output span_t sp,
  output logic  fits
);
  localparam cnt_t LIMIT = cnt_t'(2 ** RB);

  cnt_t tot, beg, fin;

  always_comb begin
    tot = ax.act + ax.fp + ax.bp + ax.sw - cnt_t'(1);
    if (IS_VERT) begin
      beg = ax.bp + ax.sw - cnt_t'(1);
      fin = tot - ax.fp;
    end else begin
      beg = ax.bp + ax.sw;
      fin = tot + cnt_t'(1) - ax.fp;
    end
    sp.total = tot;
    sp.start = beg;
    sp.stop  = fin;
    fits     = (tot < LIMIT) && (beg < LIMIT) && (fin < LIMIT);
  end
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
  import vtg_pkg::*;
#(
  parameter int RB = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  cnt_t          h_total,
  input  cnt_t          v_total,
  output logic [RB-1:0] h_cnt,
  output logic [RB-1:0] v_cnt,
  output logic          eof
);
  logic h_last, v_last;

  assign h_last = (cnt_t'(h_cnt) == h_total);
  assign v_last = (cnt_t'(v_cnt) == v_total);
  assign eof    = run && h_last && v_last;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (run) begin
      if (h_last) begin
        h_cnt <= '0;
        v_cnt <= v_last ? '0 : v_cnt + 1'b1;
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int RANGE_BITS = 13,
  parameter int ACT_SHIFT  = 0,
  parameter int CODE_W     = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CODE_W-1:0]     vic_i,
  output logic                  hsync_o,
  output logic                  vsync_o,
  output logic                  de_o,
  output logic [RANGE_BITS-1:0] pix_x_o,
  output logic [RANGE_BITS-1:0] line_y_o,
  output logic [31:0]           frame_ctl_o,
  output logic                  err_o
);
  localparam int NAX = 2;

  preset_t pre;
  axis_t   ax  [NAX];
  span_t   sp  [NAX];
  logic [NAX-1:0] fit;

  span_t   cfg_span [NAX];
  cnt_t    cfg_sw   [NAX];
  logic [NAX-1:0] cfg_low;
  logic    valid, err_q, eof, load, new_ok;

  logic [RANGE_BITS-1:0] pos [NAX];
  logic [NAX-1:0] in_win, sync_on;

  vtg_preset #(.CODE_W(CODE_W), .ACT_SHIFT(ACT_SHIFT)) u_preset (
    .code (vic_i),
    .pre  (pre)
  );

  assign ax[0] = pre.h;
  assign ax[1] = pre.v;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    vtg_axis_calc #(.IS_VERT(g == 1), .RB(RANGE_BITS)) u_calc (
      .ax   (ax[g]),
      .sp   (sp[g]),
      .fits (fit[g])
    );
  end

  assign new_ok = pre.known && (&fit);
  assign load   = !valid || eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      err_q    <= 1'b0;
      cfg_span <= '{default: '0};
      cfg_sw   <= '{default: '0};
      cfg_low  <= '0;
    end else if (load) begin
      valid <= new_ok;
      err_q <= !new_ok;
      if (new_ok) begin
        cfg_span <= sp;
        cfg_sw[0] <= pre.h.sw;
        cfg_sw[1] <= pre.v.sw;
        cfg_low   <= {pre.v_low, pre.h_low};
      end else begin
        cfg_span <= '{default: '0};
        cfg_sw   <= '{default: '0};
        cfg_low  <= '0;
      end
    end
  end

  vtg_raster #(.RB(RANGE_BITS)) u_raster (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (valid),
    .load    (load),
    .h_total (cfg_span[0].total),
    .v_total (cfg_span[1].total),
    .h_cnt   (pos[0]),
    .v_cnt   (pos[1]),
    .eof     (eof)
  );

  for (genvar g = 0; g < NAX; g++) begin : g_win
    assign in_win[g]  = (cnt_t'(pos[g]) >= cfg_span[g].start) &&
                        (cnt_t'(pos[g]) <  cfg_span[g].stop);
    assign sync_on[g] = (cnt_t'(pos[g]) < cfg_sw[g]);
  end

  assign de_o        = valid && (&in_win);
  assign hsync_o     = valid && (sync_on[0] ^ cfg_low[0]);
  assign vsync_o     = valid && (sync_on[1] ^ cfg_low[1]);
  assign pix_x_o     = pos[0];
  assign line_y_o    = pos[1];
  assign frame_ctl_o = {2'b00, cfg_low[0], cfg_low[1], 28'd0};
  assign err_o       = err_q;
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
  parameter int RB = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic [RB-1:0] pix_x_o,
  input logic [RB-1:0] line_y_o,
  input logic [31:0]   frame_ctl_o,
  input logic          err_o
);
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x_o != '0) |-> (pix_x_o == $past(pix_x_o) + 1'b1)); // R3

  AST_Y_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_y_o) && line_y_o != '0) |->
      (pix_x_o == '0 && line_y_o == $past(line_y_o) + 1'b1)); // R3

  AST_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!de_o && !hsync_o && !vsync_o && pix_x_o == '0 &&
               line_y_o == '0 && frame_ctl_o == 32'd0)); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x_o != '0) |-> $stable(frame_ctl_o)); // R7

  AST_DE_OUT_OF_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (hsync_o == frame_ctl_o[29])); // R5

  AST_IFLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> !frame_ctl_o[31]); // R6
endmodule

bind vtg_top vtg_chk #(.RB(RANGE_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .de_o        (de_o),
  .pix_x_o     (pix_x_o),
  .line_y_o    (line_y_o),
  .frame_ctl_o (frame_ctl_o),
  .err_o       (err_o)
);

// File: tb/vtg_top_tb.sv
`timescale 1ns/1ps
module vtg_top_tb;
  localparam int RB  = 13;
  localparam int NRB = 8;
  localparam int SH  = 5;
  localparam int NV  = 3;
  // code, h act/fp/sync/bp, v act/fp/sync/bp, active-low, narrow instance error
  localparam int TBL [NV][11] = '{
    '{1,  640,  16,  96,  48,  480, 10, 2, 33, 1, 0},
    '{4,  1280, 110, 40,  220, 720, 5,  5, 20, 0, 1},
    '{16, 1920, 88,  44,  148, 1080, 4, 5, 36, 0, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] vic = 7'd1;
  logic hs, vs, de, err;
  logic [RB-1:0] x, y;
  logic [31:0] fc;
  logic n_hs, n_vs, n_de, n_err;
  logic [NRB-1:0] n_x, n_y;
  logic [31:0] n_fc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vtg_top #(.RANGE_BITS(RB), .ACT_SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .vic_i(vic), .hsync_o(hs), .vsync_o(vs),
    .de_o(de), .pix_x_o(x), .line_y_o(y), .frame_ctl_o(fc), .err_o(err));

  vtg_top #(.RANGE_BITS(NRB), .ACT_SHIFT(SH)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .vic_i(vic), .hsync_o(n_hs), .vsync_o(n_vs),
    .de_o(n_de), .pix_x_o(n_x), .line_y_o(n_y), .frame_ctl_o(n_fc), .err_o(n_err));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_frame_start();
    repeat (2) @(negedge clk);
    while (!(x == '0 && y == '0)) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int htot, vtot, hst, hen, vst, ven, ha, va, hsw, vsw, low, nfr;
    int maxx, maxy, decnt, fx, fy, lx, ly, hcnt, vcnt;
    bit seen;
    logic [31:0] last_fc;
    string rq;

    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "flags in reset", {28'd0, hs, vs, de, err}, 0);
    chk("R1", "position in reset", int'(x) + int'(y), 0);
    chk("R1", "frame_ctl in reset", fc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flags after reset", {28'd0, hs, vs, de, err}, 0);

    // table walk: one full frame per code
    for (int r = 0; r < NV; r++) begin
      rq   = (r == 0) ? "R2" : "R10";
      vic  = 7'(TBL[r][0]);
      ha   = TBL[r][1] >> SH;
      va   = TBL[r][5] >> SH;
      hsw  = TBL[r][3];
      vsw  = TBL[r][7];
      low  = TBL[r][9];
      htot = ha + TBL[r][2] + hsw + TBL[r][4] - 1;
      vtot = va + TBL[r][6] + vsw + TBL[r][8] - 1;
      hst  = TBL[r][4] + hsw;
      hen  = htot + 1 - TBL[r][2];
      vst  = TBL[r][8] + vsw - 1;
      ven  = vtot - TBL[r][6];
      nfr  = (htot + 1) * (vtot + 1);
      wait_frame_start();
      maxx = 0; maxy = 0; decnt = 0; hcnt = 0; vcnt = 0;
      fx = -1; fy = -1; lx = -1; ly = -1; seen = 1'b0;
      for (int i = 0; i < nfr; i++) begin
        if (int'(x) > maxx) maxx = int'(x);
        if (int'(y) > maxy) maxy = int'(y);
        if (de) begin
          decnt++;
          if (!seen) begin fx = int'(x); fy = int'(y); seen = 1'b1; end
          lx = int'(x); ly = int'(y);
        end
        if (y == '0 && (int'(hs) != low)) hcnt++;
        if (int'(vs) != low) vcnt++;
        @(negedge clk);
      end
      chk(rq, "err_o", err, 0);
      chk("R3", "last pixel count", maxx, htot);
      chk("R3", "last line count", maxy, vtot);
      chk("R3", "frame wrap position", int'(x) + int'(y), 0);
      chk("R4 R11", "active pixel count", decnt, ha * va);
      chk("R4", "first active x", fx, hst);
      chk("R4", "first active y", fy, vst);
      chk("R4", "last active x", lx, hen - 1);
      chk("R4", "last active y", ly, ven - 1);
      chk("R5", "hsync width", hcnt, hsw);
      chk("R5", "vsync cycles", vcnt, vsw * (htot + 1));
      chk("R6", "frame_ctl", fc, low ? 32'h3000_0000 : 0);
      chk("R9", "narrow err", n_err, TBL[r][10]);
      if (TBL[r][10] != 0)
        chk("R9", "narrow idle", {29'd0, n_de, n_hs, n_vs} + int'(n_x), 0);
    end

    // R7: code change mid-frame waits for frame end
    vic = 7'd1;
    repeat (100) @(negedge clk);
    chk("R7", "x mid frame", x, 100);
    chk("R7", "frame_ctl mid frame", fc, 0);
    last_fc = fc;
    while (!(x == '0 && y == '0)) begin
      last_fc = fc;
      @(negedge clk);
    end
    chk("R7", "frame_ctl on last pixel", last_fc, 0);
    chk("R7", "frame_ctl new frame", fc, 32'h3000_0000);

    // R8: unknown code
    repeat (50) @(negedge clk);
    vic = 7'd2;
    repeat (5) @(negedge clk);
    chk("R8", "err before frame end", err, 0);
    for (int i = 0; i < 12000 && !err; i++) @(negedge clk);
    chk("R8", "err after unknown code", err, 1);
    repeat (20) @(negedge clk);
    chk("R8", "idle flags", {29'd0, de, hs, vs}, 0);
    chk("R8", "idle position", int'(x) + int'(y), 0);
    chk("R8", "idle frame_ctl", fc, 0);
    chk("R8", "narrow err unknown", n_err, 1);
    vic = 7'd4;
    @(negedge clk);
    chk("R8", "err cleared", err, 0);
    chk("R8", "restart x", x, 0);
    @(negedge clk);
    chk("R8", "counting x", x, 1);
    chk("R10", "frame_ctl code 4", fc, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule